// File: doc/BRIEF.md
# Slow-clock system timer

This block is a system timer for a chip that has a 32768 Hz slow clock next to its main bus clock. A real-time counter runs in the slow-clock domain and advances once per programmable number of slow ticks. Software reads the counter over a simple register bus and gets a coherent value, because the count crosses into the bus domain in Gray code. An absolute alarm compares a target count against the counter. A periodic interval timer produces a fixed-rate tick. All events share one interrupt line. The interrupt is gated by a mask that software sets and clears one bit at a time.

Software uses the interval timer for a periodic tick, and the alarm for one-shot events. To arm the alarm it reads the counter and writes the present count plus a delay. Status is cleared by reading it, so an interrupt handler reads the status register once and acts on every flag it returns. A watchdog-overflow flag exists as a status bit position only, and no logic ever sets it.

Configuration written over the bus is used by the slow domain directly. Writing the prescale or period register also sends a restart request across the domain boundary, which takes two to three slow ticks to arrive.

Top module: `slow_sys_timer`

## Requirements
- R1: After reset the status, mask, period, alarm and counter registers read 0, the prescale register reads 32768, and irq is low.
- R2: The counter advances once every N slow ticks, where N is the value of the prescale register. A value of 0 means 65536. With the reset value of 32768 the counter does not move for many thousands of slow ticks.
- R3: Writing the prescale register clears the counter and restarts the prescaler.
- R4: Counter reads are coherent. With a prescale of 1, each read taken on consecutive bus clocks returns the previous value or the previous value plus one, modulo 2^CNT_W.
- R5: The alarm flag (status bit 3) is set when the counter advances onto the value held in the alarm register. It is not set before that.
- R6: If the alarm value equals the counter's present value, the alarm flag is not set until the counter has advanced 2^CNT_W times (2^20 by default) and wrapped back onto that value.
- R7: With a nonzero period P, the interval flag (status bit 0) is set once every P slow ticks, independently of the prescale. A period of 0 stops the interval timer.
- R8: The increment flag (status bit 2) is set on each counter advance, and only on an advance.
- R9: Reading status returns every pending flag and clears it. A flag raised in the same cycle as the read stays pending. Bit 1 (watchdog overflow) always reads 0.
- R10: Writing to 0x14 sets the mask bits that are 1 in the data. Writing to 0x18 clears them. The mask reads at 0x1C, and its bit positions match the status bits.
- R11: irq is high exactly while some status bit is both pending and enabled in the mask.
- R12: The register map is: period 0x04, prescale 0x0C, status 0x10, mask 0x1C, alarm 0x20, counter 0x24. Read data appears one bus clock after rd_en. Every other address, including 0x14 and 0x18, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sclk | input | 1 | 32768 Hz slow clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (8) | Byte address of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid the clock after rd_en |
| irq | output | 1 | Shared timer interrupt |

## Verification
The hardest case to reach is the alarm armed at the counter's present value, which fires only after a full wrap of the counter. The bench instantiates the timer with a 12-bit counter so that the wrap takes about 4096 slow ticks. First it sets a prescale of 0, which freezes the counter at its cleared value of 0. It then writes the alarm as 0 and restarts the counter with a prescale of 1. It checks that no alarm is flagged midway through the wrap, and that the alarm is flagged once the wrap has passed. Counter coherence is exercised with reads on every bus clock while the slow clock runs at a period that is not a multiple of the bus period.

// File: rtl/slow_sys_timer.sv
module slow_sys_timer #(
  parameter int CNT_W   = 20,
  parameter int PSC_W   = 16,
  parameter int PIT_W   = 16,
  parameter int PSC_RST = 32768,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_PER = AW'(8'h04);
  localparam logic [AW-1:0] A_RTM = AW'(8'h0C);
  localparam logic [AW-1:0] A_SR  = AW'(8'h10);
  localparam logic [AW-1:0] A_IER = AW'(8'h14);
  localparam logic [AW-1:0] A_IDR = AW'(8'h18);
  localparam logic [AW-1:0] A_IMR = AW'(8'h1C);
  localparam logic [AW-1:0] A_ALM = AW'(8'h20);
  localparam logic [AW-1:0] A_CNT = AW'(8'h24);

  // bus-domain registers
  logic [PSC_W-1:0] rt_q;
  logic [PIT_W-1:0] pr_q;
  logic [CNT_W-1:0] alm_q;
  logic [3:0]       imr_q, sr_q, ev_set;
  logic             rt_tgl, pr_tgl;
  logic [DW-1:0]    rdata_q, rd_mux;
  logic [CNT_W-1:0] g1_q, g2_q, cnt_b;
  logic [2:0]       pit_s, inc_s, alm_s;

  // slow-domain registers
  logic [2:0]       rs_q, ps_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q, gry_q;
  logic [PIT_W-1:0] pit_q;
  logic             pit_t, inc_t, alm_t;

  logic wr_rt, wr_per, wr_alm, wr_ier, wr_idr, rd_sr;
  assign wr_rt  = wr_en && addr == A_RTM;
  assign wr_per = wr_en && addr == A_PER;
  assign wr_alm = wr_en && addr == A_ALM;
  assign wr_ier = wr_en && addr == A_IER;
  assign wr_idr = wr_en && addr == A_IDR;
  assign rd_sr  = rd_en && addr == A_SR;

  logic unused_bits;
  assign unused_bits = ^wdata[DW-1:CNT_W];

  assign ev_set = {alm_s[2] ^ alm_s[1], inc_s[2] ^ inc_s[1], 1'b0, pit_s[2] ^ pit_s[1]};
  assign irq    = |(sr_q & imr_q);
  assign rdata  = rdata_q;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) cnt_b[i] = ^(g2_q >> i);
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PER:   rd_mux = DW'(pr_q);
      A_RTM:   rd_mux = DW'(rt_q);
      A_SR:    rd_mux = DW'(sr_q);
      A_IMR:   rd_mux = DW'(imr_q);
      A_ALM:   rd_mux = DW'(alm_q);
      A_CNT:   rd_mux = DW'(cnt_b);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q    <= PSC_W'(PSC_RST);
      pr_q    <= '0;
      alm_q   <= '0;
      imr_q   <= '0;
      sr_q    <= '0;
      rt_tgl  <= 1'b0;
      pr_tgl  <= 1'b0;
      rdata_q <= '0;
      g1_q    <= '0;
      g2_q    <= '0;
      pit_s   <= '0;
      inc_s   <= '0;
      alm_s   <= '0;
    end else begin
      g1_q  <= gry_q;
      g2_q  <= g1_q;
      pit_s <= {pit_s[1:0], pit_t};
      inc_s <= {inc_s[1:0], inc_t};
      alm_s <= {alm_s[1:0], alm_t};
      if (wr_rt) begin
        rt_q   <= wdata[PSC_W-1:0];
        rt_tgl <= ~rt_tgl;
      end
      if (wr_per) begin
        pr_q   <= wdata[PIT_W-1:0];
        pr_tgl <= ~pr_tgl;
      end
      if (wr_alm) alm_q <= wdata[CNT_W-1:0];
      if (wr_ier)      imr_q <= imr_q | wdata[3:0];
      else if (wr_idr) imr_q <= imr_q & ~wdata[3:0];
      sr_q <= (rd_sr ? 4'b0 : sr_q) | ev_set;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  logic             restart, prestart;
  logic [PSC_W-1:0] psc_top;
  logic [CNT_W-1:0] cnt_nx;
  assign restart  = rs_q[2] ^ rs_q[1];
  assign prestart = ps_q[2] ^ ps_q[1];
  assign psc_top  = rt_q - 1'b1;
  assign cnt_nx   = cnt_q + 1'b1;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q  <= '0;
      ps_q  <= '0;
      psc_q <= '0;
      cnt_q <= '0;
      gry_q <= '0;
      inc_t <= 1'b0;
      alm_t <= 1'b0;
    end else begin
      rs_q <= {rs_q[1:0], rt_tgl};
      ps_q <= {ps_q[1:0], pr_tgl};
      if (restart) begin
        psc_q <= '0;
        cnt_q <= '0;
        gry_q <= '0;
      end else if (psc_q == psc_top) begin
        psc_q <= '0;
        cnt_q <= cnt_nx;
        gry_q <= cnt_nx ^ (cnt_nx >> 1);
        inc_t <= ~inc_t;
        if (cnt_nx == alm_q) alm_t <= ~alm_t;
      end else begin
        psc_q <= psc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pit_q <= '0;
      pit_t <= 1'b0;
    end else if (prestart) begin
      pit_q <= pr_q;
    end else if (pr_q == '0) begin
      pit_q <= '0;
    end else if (pit_q == '0) begin
      pit_q <= pr_q;
    end else if (pit_q == PIT_W'(1)) begin
      pit_q <= pr_q;
      pit_t <= ~pit_t;
    end else begin
      pit_q <= pit_q - 1'b1;
    end
  end
endmodule

// File: rtl/slow_sys_timer_chk.sv
module slow_sys_timer_chk #(
  parameter int CNT_W = 20,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [3:0]       wbits,
  input logic [DW-1:0]    rdata,
  input logic             irq,
  input logic [3:0]       sr_q,
  input logic [3:0]       ev_set,
  input logic [3:0]       imr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] alm_q,
  input logic             alm_t
);
  localparam logic [AW-1:0] C_SR  = AW'(8'h10);
  localparam logic [AW-1:0] C_IER = AW'(8'h14);
  localparam logic [AW-1:0] C_IDR = AW'(8'h18);
  localparam logic [AW-1:0] C_GAP = AW'(8'h08);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_SR) |=> ((sr_q & ~$past(ev_set)) == 4'b0));

  a_r10_ier_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_IER) |=> ((imr_q & $past(wbits)) == $past(wbits)));

  a_r10_idr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_IDR) |=> ((imr_q & $past(wbits)) == 4'b0));

  a_r11_idr_all_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_IDR && wbits == 4'hF) |=> !irq);

  a_r5_alarm_on_match: assert property (@(posedge sclk) disable iff (!rst_n)
    (alm_t != $past(alm_t)) |-> (cnt_q == alm_q));

  a_r12_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_GAP) |=> (rdata == '0));
endmodule

bind slow_sys_timer slow_sys_timer_chk #(.CNT_W(CNT_W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wbits(wdata[3:0]), .rdata(rdata), .irq(irq), .sr_q(sr_q),
  .ev_set(ev_set), .imr_q(imr_q), .cnt_q(cnt_q), .alm_q(alm_q), .alm_t(alm_t)
);

// File: tb/slow_sys_timer_tb.sv
`timescale 1ns/1ps
module slow_sys_timer_tb;
  localparam int CW = 12;
  localparam logic [31:0] CMASK = (32'd1 << CW) - 1;

  logic clk = 0, sclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;

  int nchk = 0, nfail = 0, ncyc = 0;
  logic [3:0] m_mask = 0;
  bit mon_on = 0;

  always #10 clk = ~clk;
  always #115 sclk = ~sclk;

  slow_sys_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", ncyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // R11 per-clock model comparison: with the model mask empty irq must stay low
  always @(negedge clk) begin
    if (rst_n && mon_on && m_mask == 4'b0) begin
      nchk++;
      if (irq !== 1'b0) begin
        nfail++;
        $display("FAIL R11 irq with empty mask: got %0d expected 0", irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [31:0] act, input int lo, input int hi);
    nchk++;
    if (int'(act) < lo || int'(act) > hi) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 0;
    if (a == 8'h14) m_mask = m_mask | d[3:0];
    if (a == 8'h18) m_mask = m_mask & ~d[3:0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(posedge clk);
    #1;
    rd_en = 0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge sclk);
    @(negedge clk);
  endtask

  logic [31:0] v, a0, b0, prev, cur;
  int bad, npit;
  realtime t_end;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    mon_on = 1;

    // R1 reset state
    rd(8'h10, v); chk("R1 status", v, 0);
    rd(8'h1C, v); chk("R1 mask", v, 0);
    rd(8'h0C, v); chk("R1 prescale", v, 32768);
    rd(8'h04, v); chk("R1 period", v, 0);
    rd(8'h20, v); chk("R1 alarm", v, 0);
    rd(8'h24, v); chk("R1 counter", v, 0);
    chk("R1 irq", irq, 0);

    // R2 default prescale: no advance
    ticks(40);
    rd(8'h24, v); chk("R2 default prescale holds", v, 0);

    // R12 unused addresses
    rd(8'h00, v); chk("R12 addr 0x00", v, 0);
    rd(8'h08, v); chk("R12 addr 0x08", v, 0);
    rd(8'h14, v); chk("R12 addr 0x14", v, 0);
    rd(8'h18, v); chk("R12 addr 0x18", v, 0);
    rd(8'h28, v); chk("R12 addr 0x28", v, 0);

    // R2 prescale of 1
    wr(8'h0C, 1);
    ticks(5);
    rd(8'h24, a0);
    ticks(50);
    rd(8'h24, b0);
    chk_rng("R2 prescale 1 rate", (b0 - a0) & CMASK, 49, 51);

    // R3 restart on prescale write
    chk_rng("R3 counter before restart", b0, 50, 200);
    wr(8'h0C, 1);
    ticks(6);
    rd(8'h24, v); chk_rng("R3 counter cleared", v, 0, 7);

    // R4 coherent reads on every bus clock
    @(negedge clk);
    rd_en = 1; addr = 8'h24;
    @(negedge clk);
    prev = rdata;
    bad = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cur = rdata;
      if (((cur - prev) & CMASK) > 1) bad++;
      prev = cur;
    end
    rd_en = 0;
    chk("R4 steps of 0 or 1", bad, 0);

    // R2 prescale of 4
    wr(8'h0C, 4);
    ticks(6);
    rd(8'h24, a0);
    ticks(80);
    rd(8'h24, b0);
    chk_rng("R2 prescale 4 rate", (b0 - a0) & CMASK, 19, 21);

    // R8 and R9: increment flag, clear on read, watchdog bit
    wr(8'h0C, 1);
    ticks(6);
    wr(8'h0C, 0);
    ticks(6);
    rd(8'h10, v);
    chk("R8 increment flag pending", (v >> 2) & 1, 1);
    chk("R9 watchdog bit reads 0", (v >> 1) & 1, 0);
    rd(8'h10, v); chk("R9 status cleared by read", v, 0);
    ticks(20);
    rd(8'h10, v); chk("R8 no flag without advance", v, 0);

    // R10 mask set and clear
    wr(8'h14, 32'hD);
    rd(8'h1C, v); chk("R10 enable sets", v, 32'hD);
    wr(8'h18, 32'h4);
    rd(8'h1C, v); chk("R10 disable clears", v, 32'h9);
    wr(8'h18, 32'hF);
    rd(8'h1C, v); chk("R10 disable all", v, 0);

    // R11 irq = pending and enabled
    wr(8'h0C, 1);
    ticks(6);
    chk("R11 irq masked", irq, 0);
    wr(8'h14, 32'h4);
    @(negedge clk);
    chk("R11 irq enabled", irq, 1);
    wr(8'h18, 32'h4);
    @(negedge clk);
    chk("R11 irq masked again", irq, 0);
    rd(8'h10, v); chk("R11 flag still pending", (v >> 2) & 1, 1);

    // R5 alarm at an absolute value
    rd(8'h24, a0);
    wr(8'h20, (a0 + 40) & CMASK);
    rd(8'h10, v);
    ticks(30);
    rd(8'h10, v); chk("R5 alarm not early", (v >> 3) & 1, 0);
    ticks(25);
    rd(8'h10, v); chk("R5 alarm fires", (v >> 3) & 1, 1);

    // R7 interval timer rate
    wr(8'h04, 8);
    wr(8'h18, 32'hF);
    wr(8'h14, 32'h1);
    rd(8'h10, v);
    npit = 0;
    t_end = $realtime + 160 * 230.0;
    while ($realtime < t_end) begin
      if (irq) begin
        rd(8'h10, v);
        if (v[0]) npit++;
      end else begin
        @(negedge clk);
      end
    end
    chk_rng("R7 period 8 over 160 ticks", npit, 18, 21);
    wr(8'h18, 32'hF);

    // R7 period 0 disables
    wr(8'h04, 0);
    ticks(6);
    rd(8'h10, v);
    ticks(30);
    rd(8'h10, v); chk("R7 period 0 stops", v & 1, 0);

    // R6 alarm equal to present count waits a full wrap
    wr(8'h0C, 0);
    ticks(6);
    wr(8'h20, 0);
    rd(8'h10, v);
    wr(8'h0C, 1);
    ticks(2000);
    rd(8'h10, v); chk("R6 no alarm mid wrap", (v >> 3) & 1, 0);
    ticks(2200);
    rd(8'h10, v); chk("R6 alarm after wrap", (v >> 3) & 1, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule